// File: doc/BRIEF.md
# Mixed-Mode Registered Parallel Multiplier

This block multiplies two 16-bit operands into a 32-bit product. Each operand is held in its own input register together with a mode bit, and that bit says whether the operand is two's complement or unsigned. Signed-by-signed, unsigned-by-unsigned and mixed products therefore all come from the same array. A rounding request is latched along with the operands. A format-adjust control is applied to the product before it is split. Format adjust gives a 31-bit result in which the redundant sign bit is removed and the sign is copied into the top bit of the low half.

The upper and lower product halves each have their own output register and their own load strobe. A feedthrough control makes both half registers transparent, so the product reaches the outputs combinationally. A select input chooses which half is driven onto the shared 16-bit product port. The low half also has a second path back out on the Y port. Three-state pins are modelled as a data bus plus an enable flag, and a disabled bus reads as zero.

All registers share one clock. Each register has its own load strobe, which stands in for its own independent clock. Reset is asynchronous and active low. Its release is synchronised inside the block.

Top module: `mixmul16`

## Requirements
- R1: With both mode bits low, the product equals the unsigned product of the latched operands. The upper half appears on the high output and the lower half on the low output.
- R2: A mode bit of 1 makes its operand two's complement, and the bit is latched only with its own operand. All four mode combinations give the correctly signed 32-bit product modulo 2^32.
- R3: A latched rounding request adds 2^15 to the 32-bit product before it is split. The request is latched on any operand load strobe and holds its value between strobes.
- R4: With format adjust high, the rounding increment is 2^14. With s the rounded 32-bit sum, the upper half is s[30:15] and the lower half is {s[30], s[14:0]}.
- R5: The X register (value and mode) changes only on a clock edge with x_ld high. The Y register changes only on an edge with y_ld high.
- R6: The upper half register loads on an edge with msp_ld high, and the lower half register loads on an edge with lsp_ld high. When an operand load and a half-register load fall on the same edge, the half register takes the product of the operands held before that edge.
- R7: While flow_thru is high, both outputs follow the current product combinationally and neither half register loads. After flow_thru falls, the previously stored halves reappear.
- R8: sel_msp = 1 puts the upper half on prod_out and sel_msp = 0 puts the lower half there. prod_en equals prod_oe, and prod_out reads 0 while prod_oe is low.
- R9: y_out carries the lower half and y_en equals lsp_oe. y_out reads 0 while lsp_oe is low.
- R10: After reset, every register holds zero, so both enabled outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in | input | 16 | X operand |
| x_tc | input | 1 | X mode: 1 = two's complement, 0 = unsigned |
| x_ld | input | 1 | Load strobe for the X register |
| y_in | input | 16 | Y operand |
| y_tc | input | 1 | Y mode: 1 = two's complement, 0 = unsigned |
| y_ld | input | 1 | Load strobe for the Y register |
| rnd | input | 1 | Rounding request, latched with either operand |
| fmt_adj | input | 1 | Format adjust for the 31-bit result |
| msp_ld | input | 1 | Load strobe for the upper-half register |
| lsp_ld | input | 1 | Load strobe for the lower-half register |
| flow_thru | input | 1 | Makes both half registers transparent |
| sel_msp | input | 1 | 1 = upper half on prod_out, 0 = lower half |
| prod_oe | input | 1 | Enable for the product port |
| lsp_oe | input | 1 | Enable for the lower half on the Y port |
| prod_out | output | 16 | Product port data |
| prod_en | output | 1 | Product port drive flag |
| y_out | output | 16 | Lower half on the Y port |
| y_en | output | 1 | Y port drive flag |

## Verification
Two things can fall on the same clock edge: a new operand can be latched while the half registers load. The bench provokes this by pulsing both operand strobes and both half strobes on one edge. It expects the outputs to show the product of the previous operand pair, and after a later half-register load, the product of the new pair. Rounding and format adjust are also exercised together, where the increment moves from 2^14 to 2^15 depending on format adjust. A feedthrough phase that carries ignored load strobes shows that the stored halves survive it.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;
  localparam int unsigned MM_W = 16;

  typedef enum logic {
    HALF_LSP = 1'b0,
    HALF_MSP = 1'b1
  } half_e;
endpackage

// File: rtl/mm_rst_sync.sv
module mm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_r;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_r[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= '0;
    else        sync_r <= sync_n;
  end

  assign rst_sn = sync_r[STAGES-1];
endmodule

// File: rtl/mm_opnd_reg.sv
module mm_opnd_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic         tc_d,
  output logic [W-1:0] q,
  output logic         tc_q
);
  logic [W-1:0] val_r, val_n;
  logic         tc_r, tc_n;

  always_comb begin
    val_n = val_r;
    tc_n  = tc_r;
    if (ld) begin
      val_n = d;
      tc_n  = tc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_r <= '0;
      tc_r  <= 1'b0;
    end else begin
      val_r <= val_n;
      tc_r  <= tc_n;
    end
  end

  assign q    = val_r;
  assign tc_q = tc_r;
endmodule

// File: rtl/mm_prod_core.sv
module mm_prod_core #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic         x_tc,
  input  logic [W-1:0] y,
  input  logic         y_tc,
  input  logic         rnd,
  input  logic         fa,
  output logic [W-1:0] msp,
  output logic [W-1:0] lsp
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned EW = PW + 2;

  logic signed [W:0]    xs, ys;
  logic signed [EW-1:0] xw, yw;
  logic [PW-1:0]        prod, rinc, sum;

  always_comb begin
    xs   = $signed({x_tc & x[W-1], x});
    ys   = $signed({y_tc & y[W-1], y});
    xw   = EW'(xs);
    yw   = EW'(ys);
    prod = PW'(xw * yw);
    rinc = '0;
    if (rnd) begin
      if (fa) rinc[W-2] = 1'b1;
      else    rinc[W-1] = 1'b1;
    end
    sum = prod + rinc;
    if (fa) begin
      msp = sum[PW-2:W-1];
      lsp = {sum[PW-2], sum[W-2:0]};
    end else begin
      msp = sum[PW-1:W];
      lsp = sum[W-1:0];
    end
  end
endmodule

// File: rtl/mm_half_reg.sv
module mm_half_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         ft,
  input  logic [W-1:0] d,
  output logic [W-1:0] o
);
  logic [W-1:0] q_r, q_n;
  logic         cap_en;

  always_comb begin
    cap_en = ld & ~ft;
    q_n    = cap_en ? d : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_n;
  end

  assign o = ft ? d : q_r;
endmodule

// File: rtl/mm_out_steer.sv
module mm_out_steer
  import mixmul_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         sel_msp,
  input  logic         prod_oe,
  input  logic         lsp_oe,
  input  logic [W-1:0] msp,
  input  logic [W-1:0] lsp,
  output logic [W-1:0] prod_out,
  output logic         prod_en,
  output logic [W-1:0] y_out,
  output logic         y_en
);
  half_e src;

  always_comb begin
    src      = half_e'(sel_msp);
    prod_out = '0;
    if (prod_oe) prod_out = (src == HALF_MSP) ? msp : lsp;
    prod_en  = prod_oe;
    y_out    = lsp_oe ? lsp : '0;
    y_en     = lsp_oe;
  end
endmodule

// File: rtl/mixmul16.sv
module mixmul16
  import mixmul_pkg::*;
#(
  parameter int unsigned W = MM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x_in,
  input  logic         x_tc,
  input  logic         x_ld,
  input  logic [W-1:0] y_in,
  input  logic         y_tc,
  input  logic         y_ld,
  input  logic         rnd,
  input  logic         fmt_adj,
  input  logic         msp_ld,
  input  logic         lsp_ld,
  input  logic         flow_thru,
  input  logic         sel_msp,
  input  logic         prod_oe,
  input  logic         lsp_oe,
  output logic [W-1:0] prod_out,
  output logic         prod_en,
  output logic [W-1:0] y_out,
  output logic         y_en
);
  logic         rst_sn;
  logic [W-1:0] x_q, y_q;
  logic         x_tc_q, y_tc_q;
  logic         rnd_r, rnd_n;
  logic [W-1:0] core_msp, core_lsp;
  logic [W-1:0] msp_o, lsp_o;

  mm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  mm_opnd_reg #(.W(W)) u_xreg (
    .clk(clk), .rst_n(rst_sn), .ld(x_ld), .d(x_in), .tc_d(x_tc),
    .q(x_q), .tc_q(x_tc_q)
  );

  mm_opnd_reg #(.W(W)) u_yreg (
    .clk(clk), .rst_n(rst_sn), .ld(y_ld), .d(y_in), .tc_d(y_tc),
    .q(y_q), .tc_q(y_tc_q)
  );

  always_comb begin
    rnd_n = (x_ld | y_ld) ? rnd : rnd_r;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rnd_r <= 1'b0;
    else         rnd_r <= rnd_n;
  end

  mm_prod_core #(.W(W)) u_core (
    .x(x_q), .x_tc(x_tc_q), .y(y_q), .y_tc(y_tc_q),
    .rnd(rnd_r), .fa(fmt_adj), .msp(core_msp), .lsp(core_lsp)
  );

  mm_half_reg #(.W(W)) u_msp (
    .clk(clk), .rst_n(rst_sn), .ld(msp_ld), .ft(flow_thru),
    .d(core_msp), .o(msp_o)
  );

  mm_half_reg #(.W(W)) u_lsp (
    .clk(clk), .rst_n(rst_sn), .ld(lsp_ld), .ft(flow_thru),
    .d(core_lsp), .o(lsp_o)
  );

  mm_out_steer #(.W(W)) u_steer (
    .sel_msp(sel_msp), .prod_oe(prod_oe), .lsp_oe(lsp_oe),
    .msp(msp_o), .lsp(lsp_o),
    .prod_out(prod_out), .prod_en(prod_en), .y_out(y_out), .y_en(y_en)
  );
endmodule

// File: rtl/mixmul16_chk.sv
module mixmul16_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_sn,
  input logic         x_ld,
  input logic [W-1:0] x_q,
  input logic         flow_thru,
  input logic         msp_ld,
  input logic         sel_msp,
  input logic         prod_oe,
  input logic [W-1:0] core_msp,
  input logic [W-1:0] prod_out,
  input logic         prod_en,
  input logic [W-1:0] y_out,
  input logic         y_en
);
  AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !$past(x_ld) |-> $stable(x_q)); // R5

  AST_MSP_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (!flow_thru && !$past(flow_thru) && !$past(msp_ld) && sel_msp &&
     $past(sel_msp) && prod_oe && $past(prod_oe)) |-> $stable(prod_out)); // R6

  AST_FT_PASS: assert property (@(posedge clk) disable iff (!rst_sn)
    (flow_thru && prod_oe && sel_msp) |-> (prod_out == core_msp)); // R7

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    !prod_en |-> (prod_out == '0)); // R8

  AST_Y_LSP_MATCH: assert property (@(posedge clk) disable iff (!rst_sn)
    (prod_en && y_en && !sel_msp) |-> (prod_out == y_out)); // R9
endmodule

bind mixmul16 mixmul16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .x_ld(x_ld), .x_q(x_q),
  .flow_thru(flow_thru), .msp_ld(msp_ld), .sel_msp(sel_msp),
  .prod_oe(prod_oe), .core_msp(core_msp), .prod_out(prod_out),
  .prod_en(prod_en), .y_out(y_out), .y_en(y_en)
);

// File: tb/test_mixmul16.sv
module test_mixmul16;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] x_in, y_in;
  logic        x_tc, x_ld, y_tc, y_ld, rnd, fmt_adj;
  logic        msp_ld, lsp_ld, flow_thru, sel_msp, prod_oe, lsp_oe;
  logic [15:0] prod_out, y_out;
  logic        prod_en, y_en;

  always #4 clk = ~clk;

  mixmul16 i_mixmul16 (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .x_tc(x_tc), .x_ld(x_ld),
    .y_in(y_in), .y_tc(y_tc), .y_ld(y_ld), .rnd(rnd), .fmt_adj(fmt_adj),
    .msp_ld(msp_ld), .lsp_ld(lsp_ld), .flow_thru(flow_thru),
    .sel_msp(sel_msp), .prod_oe(prod_oe), .lsp_oe(lsp_oe),
    .prod_out(prod_out), .prod_en(prod_en), .y_out(y_out), .y_en(y_en)
  );

  typedef struct {
    logic [15:0] p;
    logic        pe;
    logic [15:0] y;
    logic        ye;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  // model state
  logic [15:0] m_x, m_y, m_msp, m_lsp;
  logic        m_xt, m_yt, m_r;

  function automatic logic [31:0] ref_prod(input logic [15:0] xv, input logic xt,
      input logic [15:0] yv, input logic yt, input logic r, input logic fa);
    longint a, b, p;
    logic [31:0] s;
    a = xt ? longint'($signed(xv)) : longint'(xv);
    b = yt ? longint'($signed(yv)) : longint'(yv);
    p = a * b;
    s = p[31:0];
    if (r) s = s + (fa ? 32'h0000_4000 : 32'h0000_8000);
    if (fa) return {s[30:15], s[30], s[14:0]};
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one edge with chosen strobes; update the model at that edge.
  task automatic step(input logic [15:0] xv, input logic xt, input logic [15:0] yv,
      input logic yt, input logic r, input logic lx, input logic ly, input logic lo);
    logic [31:0] old;
    @(negedge clk);
    x_in = xv; x_tc = xt; y_in = yv; y_tc = yt; rnd = r;
    x_ld = lx; y_ld = ly; msp_ld = lo; lsp_ld = lo;
    @(posedge clk);
    old = ref_prod(m_x, m_xt, m_y, m_yt, m_r, fmt_adj);
    if (lo && !flow_thru) begin m_msp = old[31:16]; m_lsp = old[15:0]; end
    if (lx) begin m_x = xv; m_xt = xt; end
    if (ly) begin m_y = yv; m_yt = yt; end
    if (lx || ly) m_r = r;
    @(negedge clk);
    x_ld = 0; y_ld = 0; msp_ld = 0; lsp_ld = 0;
  endtask

  task automatic expect_out(input string tag);
    exp_t e;
    logic [31:0] c;
    logic [15:0] hm, hl;
    c  = ref_prod(m_x, m_xt, m_y, m_yt, m_r, fmt_adj);
    hm = flow_thru ? c[31:16] : m_msp;
    hl = flow_thru ? c[15:0]  : m_lsp;
    e.p   = prod_oe ? (sel_msp ? hm : hl) : 16'h0;
    e.pe  = prod_oe;
    e.y   = lsp_oe ? hl : 16'h0;
    e.ye  = lsp_oe;
    e.tag = tag;
    exp_q.push_back(e);
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic mult(input logic [15:0] xv, input logic xt, input logic [15:0] yv,
      input logic yt, input logic r, input logic fa, input string tag);
    fmt_adj = fa;
    step(xv, xt, yv, yt, r, 1, 1, 0);
    step(xv, xt, yv, yt, r, 0, 0, 1);
    expect_out(tag);
  endtask

  // monitor: compares away from the active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " prod_out"}, {16'h0, prod_out}, {16'h0, e.p});
        chk({e.tag, " prod_en"},  {31'h0, prod_en},  {31'h0, e.pe});
        chk({e.tag, " y_out"},    {16'h0, y_out},    {16'h0, e.y});
        chk({e.tag, " y_en"},     {31'h0, y_en},     {31'h0, e.ye});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    x_in = 0; x_tc = 0; x_ld = 0; y_in = 0; y_tc = 0; y_ld = 0; rnd = 0;
    fmt_adj = 0; msp_ld = 0; lsp_ld = 0; flow_thru = 0;
    sel_msp = 1; prod_oe = 1; lsp_oe = 1;
    m_x = 0; m_y = 0; m_xt = 0; m_yt = 0; m_r = 0; m_msp = 0; m_lsp = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    expect_out("R10 reset");

    mult(16'hFFFF, 0, 16'hFFFF, 0, 0, 0, "R1 unsigned max");
    mult(16'd1234, 0, 16'd5678, 0, 0, 0, "R1 unsigned mid");

    for (int k = 0; k < 4; k++) begin
      mult(16'h8000, k[0], 16'hFFFF, k[1], 0, 0, "R2 mode combo a");
      mult(16'hFFFB, k[0], 16'h0007, k[1], 0, 0, "R2 mode combo b");
    end
    mult(16'h8000, 1, 16'h8000, 1, 0, 0, "R2 signed min squared");

    mult(16'h0123, 0, 16'h4567, 0, 1, 0, "R3 round");
    mult(16'hFF00, 1, 16'h00C0, 1, 1, 0, "R3 round negative");
    // rnd input changes without a strobe: latched value holds
    step(16'h0123, 0, 16'h4567, 0, 1, 1, 1, 0);
    step(16'h0000, 0, 16'h0000, 0, 0, 0, 0, 1);
    expect_out("R3 round held");

    mult(16'h4000, 1, 16'h4000, 1, 0, 1, "R4 format adjust");
    mult(16'hC000, 1, 16'h3001, 0, 0, 1, "R4 format adjust neg");
    mult(16'h1357, 1, 16'h2468, 1, 1, 1, "R4 format adjust with round");
    mult(16'hF123, 1, 16'h0345, 1, 1, 1, "R4 adjust round negative");
    fmt_adj = 0;

    // R5: only X loads; mode input flips without strobe afterwards
    step(16'hFFFE, 1, 16'h0000, 0, 0, 1, 0, 0);
    step(16'h0003, 0, 16'hAAAA, 1, 0, 0, 0, 1);
    expect_out("R5 x only with held y");
    step(16'h0000, 0, 16'h0005, 0, 0, 0, 1, 0);
    step(16'h7777, 0, 16'h7777, 1, 0, 0, 0, 1);
    expect_out("R5 y only");

    // R6: operand and half loads on the same edge
    mult(16'h0011, 0, 16'h0022, 0, 0, 0, "R6 setup");
    step(16'h0303, 0, 16'h0404, 0, 0, 1, 1, 1);
    expect_out("R6 same edge old product");
    step(16'h0000, 0, 16'h0000, 0, 0, 0, 0, 1);
    expect_out("R6 later load new product");

    // R7: feedthrough
    @(negedge clk); flow_thru = 1;
    step(16'h1234, 1, 16'hFEDC, 1, 0, 1, 1, 0);
    expect_out("R7 feedthrough msp");
    sel_msp = 0;
    expect_out("R7 feedthrough lsp");
    step(16'h1234, 1, 16'hFEDC, 1, 0, 0, 0, 1);
    @(negedge clk); flow_thru = 0; sel_msp = 1;
    expect_out("R7 stored halves after feedthrough");

    // R8/R9 steering and enables
    mult(16'hABCD, 0, 16'h1357, 0, 0, 0, "R8 msp select");
    sel_msp = 0;
    expect_out("R8 lsp select");
    prod_oe = 0;
    expect_out("R8 product port disabled");
    prod_oe = 1; lsp_oe = 0;
    expect_out("R9 y port disabled");
    lsp_oe = 1; sel_msp = 1;
    expect_out("R9 y port lsp");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule